// File: doc/BRIEF.md
# Memory Access Unit with Conditional Swap

This block answers single-beat memory requests against a small internal byte-addressed store. Each request carries a command (read, write, swap, two eviction kinds, cache maintenance), a byte address, a size code, write data, a compare value and a set of qualifiers. A read returns the addressed bytes. A swap returns the old contents and then replaces them. A conditional swap replaces them only when the compare value matches. Requests that a cache has already answered, eviction notices and maintenance operations are absorbed without touching the store.

Writes are gated by an external `store_ok` input, so that a reservation monitor outside the block can decide whether a store takes effect. The block keeps wrapping per-requestor counters of reads, writes and swaps, and of bytes read, written and fetched as instructions. It shows them on flat output vectors. A request is accepted on a rising clock edge while `req_valid` is high. Any response appears on the following cycle for one cycle.

Top module: `mem_access_unit`

## Requirements
- R1: A request with `flag_cache_resp` high produces no response and changes no memory byte, counter or error flag.
- R2: Commands 3 and 4 (clean eviction, clean writeback) produce no response and change no memory byte or counter.
- R3: Command 0 (read) returns the selected bytes little-endian and zero-extended in `rsp_data`. Size code s selects 2^s bytes (s = 0..3). The address is aligned down to a multiple of 2^s.
- R4: Command 1 (write) stores the low 2^s bytes of `req_wdata` at the aligned address only when `store_ok` is high. With `store_ok` low, memory and the write counters are unchanged. Either way the write is answered with zero data when a response is requested.
- R5: Command 2 (swap) with `req_cond` low returns the old contents and always writes the new data.
- R6: Command 2 with `req_cond` high writes only when the compare value equals memory. At size code 3 all 64 bits of `req_cmp` are compared. At size code 2 only its low 32 bits are compared. The old contents are returned in both cases.
- R7: Command 2 with `req_cond` high at size code 0 or 1 sets the sticky `err_size` flag. It writes nothing, counts nothing and gives no response.
- R8: Command 5 (invalidate/clean) leaves memory and counters unchanged and is answered with zero data.
- R9: A response (`rsp_valid` high for one cycle) appears exactly one cycle after an accepted request, and only if `flag_needs_resp` was high.
- R10: Per requestor `req_id`, each read adds 1 to its read count and 2^s to its read bytes. A read with `req_ifetch` high also adds 2^s to its fetch bytes. Each performed write adds 1 to its write count and 2^s to its write bytes. Each performed swap adds 1 to its other-operation count. All counters wrap.
- R11: Commands 6 and 7 set the sticky `err_cmd` flag and produce no response or state change.
- R12: After reset, memory, counters, `rsp_valid` and both error flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 3 | Command code |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code, 2^code bytes |
| req_wdata | input | 64 | Write/swap data, low bytes used |
| req_cmp | input | 64 | Compare value for conditional swap |
| req_cond | input | 1 | Swap is conditional |
| req_ifetch | input | 1 | Read is an instruction fetch |
| req_id | input | ID_W | Requestor index |
| flag_cache_resp | input | 1 | A cache already answers this request |
| flag_needs_resp | input | 1 | Requester expects a response |
| store_ok | input | 1 | Plain write may take effect |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 64 | Read or old data, zero otherwise |
| err_cmd | output | 1 | Sticky unsupported-command flag |
| err_size | output | 1 | Sticky illegal conditional-swap size flag |
| rd_ops_o | output | N_REQ*CNT_W | Read counts per requestor |
| wr_ops_o | output | N_REQ*CNT_W | Write counts per requestor |
| oth_ops_o | output | N_REQ*CNT_W | Swap counts per requestor |
| rd_bytes_o | output | N_REQ*CNT_W | Bytes read per requestor |
| wr_bytes_o | output | N_REQ*CNT_W | Bytes written per requestor |
| if_bytes_o | output | N_REQ*CNT_W | Instruction-fetch bytes per requestor |

## Verification
The bench uses the defaults ADDR_W = 6, N_REQ = 4 and CNT_W = 16. With these values the store holds only 64 bytes. Every aligned address at every size can therefore be written and read back, and a final byte-by-byte sweep compares the whole store with the bench's own model. Requestor IDs rotate across all four slots, so every counter lane of every kind is checked against totals the bench computes from the sizes it issued.

// File: rtl/mem_access_unit.sv
module mem_access_unit #(
  parameter int ADDR_W = 6,
  parameter int N_REQ  = 4,
  parameter int CNT_W  = 16,
  localparam int ID_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [2:0]             req_cmd,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_size,
  input  logic [63:0]            req_wdata,
  input  logic [63:0]            req_cmp,
  input  logic                   req_cond,
  input  logic                   req_ifetch,
  input  logic [ID_W-1:0]        req_id,
  input  logic                   flag_cache_resp,
  input  logic                   flag_needs_resp,
  input  logic                   store_ok,
  output logic                   rsp_valid,
  output logic [63:0]            rsp_data,
  output logic                   err_cmd,
  output logic                   err_size,
  output logic [N_REQ*CNT_W-1:0] rd_ops_o,
  output logic [N_REQ*CNT_W-1:0] wr_ops_o,
  output logic [N_REQ*CNT_W-1:0] oth_ops_o,
  output logic [N_REQ*CNT_W-1:0] rd_bytes_o,
  output logic [N_REQ*CNT_W-1:0] wr_bytes_o,
  output logic [N_REQ*CNT_W-1:0] if_bytes_o
);
  localparam int WA_W  = ADDR_W - 3;
  localparam int WORDS = 1 << WA_W;

  logic [63:0] mem [WORDS];

  logic [2:0]  off;
  logic [7:0]  lanes;
  logic [63:0] szmask;

  always_comb begin
    case (req_size)
      2'd0:    begin off = req_addr[2:0];         lanes = 8'h01; szmask = 64'h0000_0000_0000_00ff; end
      2'd1:    begin off = {req_addr[2:1], 1'b0}; lanes = 8'h03; szmask = 64'h0000_0000_0000_ffff; end
      2'd2:    begin off = {req_addr[2], 2'b00};  lanes = 8'h0f; szmask = 64'h0000_0000_ffff_ffff; end
      default: begin off = 3'd0;                  lanes = 8'hff; szmask = '1; end
    endcase
  end

  wire [WA_W-1:0]  widx   = req_addr[ADDR_W-1:3];
  wire [63:0]      word   = mem[widx];
  wire [63:0]      rd_val = (word >> {off, 3'b000}) & szmask;
  wire [7:0]       be     = lanes << off;
  wire [63:0]      wlane  = (req_wdata & szmask) << {off, 3'b000};
  wire             cmp_eq = (req_size == 2'd3) ? (req_cmp == rd_val)
                                               : (req_cmp[31:0] == rd_val[31:0]);
  wire [CNT_W-1:0] nbytes = CNT_W'(4'd1 << req_size);

  wire live     = req_valid && !flag_cache_resp;
  wire is_rd    = live && req_cmd == 3'd0;
  wire is_wr    = live && req_cmd == 3'd1;
  wire is_sw    = live && req_cmd == 3'd2;
  wire is_mt    = live && req_cmd == 3'd5;
  wire is_bad   = live && req_cmd[2:1] == 2'b11;
  wire cond_bad = is_sw && req_cond && !req_size[1];
  wire sw_do    = is_sw && !cond_bad;
  wire wr_do    = is_wr && store_ok;
  wire do_write = wr_do || (sw_do && (!req_cond || cmp_eq));
  wire respond  = (is_rd || is_wr || sw_do || is_mt) && flag_needs_resp;

  logic [63:0] merged;
  for (genvar b = 0; b < 8; b++) begin : g_lane
    assign merged[8*b +: 8] = be[b] ? wlane[8*b +: 8] : word[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else if (do_write) begin
      mem[widx] <= merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      err_cmd   <= 1'b0;
      err_size  <= 1'b0;
    end else begin
      rsp_valid <= respond;
      rsp_data  <= (respond && (is_rd || sw_do)) ? rd_val : 64'd0;
      if (is_bad)   err_cmd  <= 1'b1;
      if (cond_bad) err_size <= 1'b1;
    end
  end

  for (genvar g = 0; g < N_REQ; g++) begin : g_req
    logic [CNT_W-1:0] c_rd, c_wr, c_ot, b_rd, b_wr, b_if;
    wire hit = (req_id == ID_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_rd <= '0; c_wr <= '0; c_ot <= '0;
        b_rd <= '0; b_wr <= '0; b_if <= '0;
      end else if (hit) begin
        if (is_rd) begin
          c_rd <= c_rd + 1'b1;
          b_rd <= b_rd + nbytes;
          if (req_ifetch) b_if <= b_if + nbytes;
        end
        if (wr_do) begin
          c_wr <= c_wr + 1'b1;
          b_wr <= b_wr + nbytes;
        end
        if (sw_do) c_ot <= c_ot + 1'b1;
      end
    end

    assign rd_ops_o  [g*CNT_W +: CNT_W] = c_rd;
    assign wr_ops_o  [g*CNT_W +: CNT_W] = c_wr;
    assign oth_ops_o [g*CNT_W +: CNT_W] = c_ot;
    assign rd_bytes_o[g*CNT_W +: CNT_W] = b_rd;
    assign wr_bytes_o[g*CNT_W +: CNT_W] = b_wr;
    assign if_bytes_o[g*CNT_W +: CNT_W] = b_if;
  end
endmodule

// File: rtl/mau_checker.sv
module mau_checker #(
  parameter int N_REQ = 4,
  parameter int CNT_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [2:0]             req_cmd,
  input logic [1:0]             req_size,
  input logic                   req_cond,
  input logic                   flag_cache_resp,
  input logic                   flag_needs_resp,
  input logic                   store_ok,
  input logic                   rsp_valid,
  input logic                   err_cmd,
  input logic                   err_size,
  input logic [N_REQ*CNT_W-1:0] wr_ops_o
);
  p_cache_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && flag_cache_resp |=> !rsp_valid);

  p_evict_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !flag_cache_resp && (req_cmd == 3'd3 || req_cmd == 3'd4) |=> !rsp_valid);

  p_store_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !flag_cache_resp && req_cmd == 3'd1 && !store_ok |=> $stable(wr_ops_o));

  p_cond_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !flag_cache_resp && req_cmd == 3'd2 && req_cond && !req_size[1]
    |=> err_size && !rsp_valid);

  p_rsp_needs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && flag_needs_resp && !flag_cache_resp));

  p_bad_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !flag_cache_resp && req_cmd[2:1] == 2'b11 |=> err_cmd && !rsp_valid);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_cmd |=> err_cmd);
endmodule

bind mem_access_unit mau_checker #(.N_REQ(N_REQ), .CNT_W(CNT_W)) u_mau_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
  .req_size(req_size), .req_cond(req_cond), .flag_cache_resp(flag_cache_resp),
  .flag_needs_resp(flag_needs_resp), .store_ok(store_ok), .rsp_valid(rsp_valid),
  .err_cmd(err_cmd), .err_size(err_size), .wr_ops_o(wr_ops_o)
);

// File: tb/mem_access_unit_bench.sv
module mem_access_unit_bench;
  localparam int ADDR_W = 6;
  localparam int N_REQ  = 4;
  localparam int CNT_W  = 16;
  localparam int NB     = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_cond = 0, req_ifetch = 0;
  logic flag_cache_resp = 0, flag_needs_resp = 0, store_ok = 0;
  logic [2:0] req_cmd = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_size = '0, req_id = '0;
  logic [63:0] req_wdata = '0, req_cmp = '0;
  logic rsp_valid, err_cmd, err_size;
  logic [63:0] rsp_data;
  logic [N_REQ*CNT_W-1:0] rd_ops_o, wr_ops_o, oth_ops_o, rd_bytes_o, wr_bytes_o, if_bytes_o;

  mem_access_unit #(.ADDR_W(ADDR_W), .N_REQ(N_REQ), .CNT_W(CNT_W)) u_mem_access_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .req_cmp(req_cmp), .req_cond(req_cond), .req_ifetch(req_ifetch),
    .req_id(req_id), .flag_cache_resp(flag_cache_resp),
    .flag_needs_resp(flag_needs_resp), .store_ok(store_ok),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err_cmd(err_cmd),
    .err_size(err_size), .rd_ops_o(rd_ops_o), .wr_ops_o(wr_ops_o),
    .oth_ops_o(oth_ops_o), .rd_bytes_o(rd_bytes_o), .wr_bytes_o(wr_bytes_o),
    .if_bytes_o(if_bytes_o)
  );

  always #5 clk = ~clk;

  logic [7:0] mref [NB];
  logic [CNT_W-1:0] m_rd [N_REQ], m_wr [N_REQ], m_ot [N_REQ];
  logic [CNT_W-1:0] m_brd [N_REQ], m_bwr [N_REQ], m_bif [N_REQ];
  logic e_cmd = 0, e_size = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [63:0] mval(int addr, int size);
    int nb = 1 << size;
    int base = addr & ~(nb - 1);
    logic [63:0] v = '0;
    for (int i = 0; i < nb; i++) v |= 64'(mref[base + i]) << (8 * i);
    return v;
  endfunction

  function automatic logic [63:0] pat(int a, int s);
    return 64'h0f1e_2d3c_4b5a_6978 ^ (64'(a) * 64'h0103_0507_0b0d_1113) ^ (64'(s) << 61);
  endfunction

  task automatic issue(string tag, logic [2:0] cmd, int addr, int size, logic [63:0] wd,
                       logic [63:0] cmp, bit cond, bit ifetch, int id, bit cache,
                       bit needs, bit sok);
    int nb = 1 << size;
    int base = addr & ~(nb - 1);
    logic [63:0] old = mval(addr, size);
    bit ev = 0, wr = 0;
    logic [63:0] ed = '0;
    if (!cache) begin
      case (cmd)
        3'd0: begin
          ev = needs; ed = old;
          m_rd[id]++; m_brd[id] += CNT_W'(nb);
          if (ifetch) m_bif[id] += CNT_W'(nb);
        end
        3'd1: begin
          ev = needs;
          if (sok) begin wr = 1; m_wr[id]++; m_bwr[id] += CNT_W'(nb); end
        end
        3'd2: begin
          if (cond && size < 2) e_size = 1;
          else begin
            ev = needs; ed = old; m_ot[id]++;
            if (!cond) wr = 1;
            else if (size == 3) wr = (cmp == old);
            else wr = (cmp[31:0] == old[31:0]);
          end
        end
        3'd3, 3'd4: ;
        3'd5: ev = needs;
        default: e_cmd = 1;
      endcase
    end
    if (wr) for (int i = 0; i < nb; i++) mref[base + i] = wd[8*i +: 8];

    req_cmd = cmd; req_addr = ADDR_W'(addr); req_size = 2'(size);
    req_wdata = wd; req_cmp = cmp; req_cond = cond; req_ifetch = ifetch;
    req_id = 2'(id); flag_cache_resp = cache; flag_needs_resp = needs;
    store_ok = sok; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(tag, "rsp_valid", 64'(rsp_valid), 64'(ev));
    if (ev) chk(tag, "rsp_data", rsp_data, ed);
    chk(tag, "err flags", {62'd0, err_cmd, err_size}, {62'd0, e_cmd, e_size});
  endtask

  task automatic rd(string tag, int addr, int size, int id = 0);
    issue(tag, 3'd0, addr, size, '0, '0, 0, 0, id, 0, 1, 1);
  endtask

  task automatic check_counters(string tag);
    for (int r = 0; r < N_REQ; r++) begin
      chk(tag, "read count",  64'(rd_ops_o  [r*CNT_W +: CNT_W]), 64'(m_rd[r]));
      chk(tag, "write count", 64'(wr_ops_o  [r*CNT_W +: CNT_W]), 64'(m_wr[r]));
      chk(tag, "swap count",  64'(oth_ops_o [r*CNT_W +: CNT_W]), 64'(m_ot[r]));
      chk(tag, "read bytes",  64'(rd_bytes_o[r*CNT_W +: CNT_W]), 64'(m_brd[r]));
      chk(tag, "write bytes", 64'(wr_bytes_o[r*CNT_W +: CNT_W]), 64'(m_bwr[r]));
      chk(tag, "fetch bytes", 64'(if_bytes_o[r*CNT_W +: CNT_W]), 64'(m_bif[r]));
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: got no completion expected completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) mref[i] = '0;
    for (int r = 0; r < N_REQ; r++) begin
      m_rd[r] = '0; m_wr[r] = '0; m_ot[r] = '0;
      m_brd[r] = '0; m_bwr[r] = '0; m_bif[r] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    chk("R12", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R12", "err flags", {62'd0, err_cmd, err_size}, 64'd0);
    check_counters("R12");
    for (int w = 0; w < NB / 8; w++) rd("R12", w * 8, 3);

    // R3 / R4 exhaustive aligned write and readback
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < NB; a += (1 << s)) begin
        issue("R4", 3'd1, a, s, pat(a, s), '0, 0, 0, (a >> s) % 4, 0, 1, 1);
        rd("R3", a, s, (a >> s + 1) % 4);
      end
    rd("R3", 13, 2, 1);
    rd("R3", 7, 1, 2);
    rd("R3", 61, 3, 3);

    // R4 store gated
    issue("R4", 3'd1, 8, 3, 64'hdead_beef_cafe_f00d, '0, 0, 0, 2, 0, 1, 0);
    rd("R4", 8, 3);
    check_counters("R4");

    // R5 unconditional swap
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < NB; a += 24 + s) begin
        issue("R5", 3'd2, a, s, pat(a + 7, s), 64'h1, 0, 0, s, 0, 1, 1);
        rd("R5", a, s);
      end

    // R6 conditional swap, match and mismatch
    issue("R6", 3'd2, 16, 3, 64'h1111_2222_3333_4444, mval(16, 3), 1, 0, 1, 0, 1, 1);
    rd("R6", 16, 3);
    issue("R6", 3'd2, 16, 3, 64'h5555_6666_7777_8888, mval(16, 3) ^ 64'h8000_0000_0000_0000, 1, 0, 1, 0, 1, 1);
    rd("R6", 16, 3);
    issue("R6", 3'd2, 36, 2, 64'h0000_0000_abcd_0123, {32'hfeed_face, mval(36, 2)[31:0]}, 1, 0, 2, 0, 1, 1);
    rd("R6", 32, 3);
    issue("R6", 3'd2, 36, 2, 64'h0000_0000_9999_9999, mval(36, 2) ^ 64'h1, 1, 0, 2, 0, 1, 1);
    rd("R6", 32, 3);

    // R7 illegal conditional size
    issue("R7", 3'd2, 40, 0, 64'h77, mval(40, 0), 1, 0, 3, 0, 1, 1);
    issue("R7", 3'd2, 42, 1, 64'h7777, mval(42, 1), 1, 0, 3, 0, 1, 1);
    rd("R7", 40, 3);
    check_counters("R7");

    // R2 evictions
    issue("R2", 3'd3, 48, 3, 64'h0badc0de0badc0de, '0, 0, 0, 0, 0, 1, 1);
    issue("R2", 3'd4, 48, 3, 64'h0badc0de0badc0de, '0, 0, 0, 1, 0, 1, 1);
    rd("R2", 48, 3);
    check_counters("R2");

    // R1 cache responding
    issue("R1", 3'd0, 48, 3, '0, '0, 0, 1, 0, 1, 1, 1);
    issue("R1", 3'd1, 48, 3, 64'h1234, '0, 0, 0, 1, 1, 1, 1);
    issue("R1", 3'd2, 48, 3, 64'h5678, '0, 0, 0, 2, 1, 1, 1);
    issue("R1", 3'd6, 48, 3, '0, '0, 0, 0, 3, 1, 1, 1);
    rd("R1", 48, 3);
    check_counters("R1");

    // R8 maintenance
    issue("R8", 3'd5, 56, 3, 64'hffff_ffff_ffff_ffff, '0, 0, 0, 0, 0, 1, 1);
    rd("R8", 56, 3);

    // R9 no response without request for one
    issue("R9", 3'd0, 24, 2, '0, '0, 0, 0, 1, 0, 0, 1);
    issue("R9", 3'd1, 24, 2, 64'h0000_0000_5a5a_a5a5, '0, 0, 0, 1, 0, 0, 1);
    issue("R9", 3'd2, 28, 2, 64'h0000_0000_1357_9bdf, '0, 0, 0, 1, 0, 0, 1);
    rd("R9", 24, 3);

    // R10 instruction fetch bytes
    for (int s = 0; s < 4; s++) issue("R10", 3'd0, 8 * s, s, '0, '0, 0, 1, s, 0, 1, 1);
    issue("R10", 3'd0, 0, 3, '0, '0, 0, 1, 3, 0, 0, 1);
    check_counters("R10");

    // R11 unsupported commands, sticky flag
    issue("R11", 3'd6, 0, 3, 64'h42, '0, 0, 0, 0, 0, 1, 1);
    issue("R11", 3'd7, 0, 3, 64'h43, '0, 0, 0, 1, 0, 1, 1);
    rd("R11", 0, 3);

    // R3 final byte sweep of the whole store
    for (int a = 0; a < NB; a++) rd("R3", a, 0, a % 4);
    check_counters("R10");

    done = 1;
    finish_run();
  end
endmodule